// File: doc/BRIEF.md
# Mode-Dependent SPI Register Access Unit

This block is the SPI slave side of a system controller's register file. A host shifts 16-bit frames into it. Each frame begins with a 4-bit header: a 2-bit address, a feedback-select bit and a read-only bit. A 12-bit data field follows. The operating mode of the controller arrives on an input port. The mode decides which write register sits behind each address and which register comes back as read data. The read data for a frame is chosen by the header of that same frame. It is shifted out during the 12 data bits of that frame.

The SPI pins are sampled into the system clock domain. A frame state machine tracks chip select and the bit count:

- States: `S_IDLE`, `S_HDR`, `S_LOAD`, `S_DATA`, `S_FULL`, `S_OVER`, `S_COMMIT`.
- Transitions:
  - IDLE to HDR on a chip-select fall.
  - HDR to LOAD on the fourth SCLK rise.
  - LOAD to DATA after one cycle.
  - DATA to FULL on the sixteenth SCLK rise.
  - FULL to COMMIT on a chip-select rise.
  - FULL to OVER on one more SCLK rise.
  - COMMIT to IDLE after one cycle.
  - HDR, LOAD, DATA and OVER go back to IDLE on a chip-select rise, and the frame is dropped.

A write to the mode-control word is checked before it is stored. A legal word is stored and pulses a watchdog retrigger strobe. An illegal word is dropped and pulses a system reset request. The watchdog timer, the system state machine and the bus transceivers are outside this block.

Top module: `sbc_spi_regif`

## Requirements
- R1: After reset:
  - all stored words are zero;
  - `glob_en`, `sdm_en` and `spi_miso` are low;
  - neither strobe is active.
- R2: Frame format and commit:
  - Frames use SPI mode 0, most significant bit first, while `spi_csn` is low.
  - Frame bit 15 is A1 and bit 14 is A0. Bit 13 is the feedback select. Bit 12 is the read-only flag. Bits 11..0 are data.
  - A frame takes effect only if exactly 16 SCLK rises occur before `spi_csn` rises. Frames of 15 or 17 bits change nothing.
- R3: Read data:
  - The first 4 MISO bits are 0. The next 12 bits are the selected feedback word, MSB first.
  - Address 00 returns `stat_in` for select 0 and `diag_in` for select 1.
  - Address 01 returns the interrupt-enable word for select 0. For select 1 it returns `irq_in` in Standby and Normal, and the special-mode word in other modes.
  - Address 10 returns the configuration word for select 0 and the general-purpose-0 word for select 1.
  - Address 11 returns the physical-layer word for select 0 and the general-purpose-1 word for select 1.
- R4: Write targets:
  - Address 01 writes the special-mode word in Start-up and Restart. In the other modes it writes the interrupt-enable word.
  - Address 10 writes the configuration word in Standby and Normal, and general-purpose 0 otherwise.
  - Address 11 writes the physical-layer word in Standby and Normal, and general-purpose 1 otherwise.
- R5: A frame with the read-only bit set writes no register. It raises neither strobe.
- R6: A mode-control write (address 00) is legal only if both of these hold:
  - the mode field, bits 7..5, is 1, 2, 3 or 4;
  - the watchdog field, bits 11..8, is 1 to 12.

  A legal word is stored, and `wd_kick` pulses for exactly one cycle. The stored word changes only together with `wd_kick`.
- R7: An illegal mode-control write leaves the stored word unchanged. `rst_req` pulses for exactly one cycle and `wd_kick` stays low.
- R8: `glob_en` equals bit 4 of the stored mode-control word. `sdm_en` equals bit 3.
- R9: `op_mode` codes are 0 Start-up, 1 Restart, 2 Standby, 3 Normal and 4 Flash. Codes 5 to 7 act as Start-up. The mode is sampled when the header completes.
- R10: Stored words change only while `spi_csn` is high, after the frame has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | SPI clock from host |
| spi_csn | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial read data to host |
| op_mode | input | 3 | Current operating mode code |
| stat_in | input | 12 | System status feedback word |
| diag_in | input | 12 | System diagnosis feedback word |
| irq_in | input | 12 | Interrupt flag feedback word |
| mode_word | output | 12 | Stored mode-control word |
| ie_word | output | 12 | Stored interrupt-enable word |
| smode_word | output | 12 | Stored special-mode word |
| cfg_word | output | 12 | Stored system configuration word |
| gp0_word | output | 12 | Stored general-purpose word 0 |
| gp1_word | output | 12 | Stored general-purpose word 1 |
| phy_word | output | 12 | Stored physical-layer control word |
| glob_en | output | 1 | Global enable from the mode-control word |
| sdm_en | output | 1 | Software development mode bit |
| wd_kick | output | 1 | One-cycle watchdog retrigger strobe |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The assertions assume that SCLK is slow against `clk`, so that two commits can never land on adjacent cycles. They also assume that `spi_csn` stays high for several cycles after each frame, so that a stored word only moves while chip select is high. The stimulus keeps each SCLK half period at 8 system clocks. It keeps chip select high for 12 clocks between frames. It holds `op_mode` and the three feedback inputs steady for the whole frame. Random frames use every header, every mode code 0 to 7 and random data fields, so legal and illegal mode-control words are both common.

// File: rtl/sbc_regif_pkg.sv
package sbc_regif_pkg;

    localparam int unsigned HDR_W      = 4;
    localparam int unsigned WD_LSB     = 8;
    localparam int unsigned WD_W       = 4;
    localparam int unsigned MC_LSB     = 5;
    localparam int unsigned MC_W       = 3;
    localparam int unsigned EN_BIT     = 4;
    localparam int unsigned SDM_BIT    = 3;

    typedef enum logic [2:0] {
        OPM_STARTUP = 3'd0,
        OPM_RESTART = 3'd1,
        OPM_STANDBY = 3'd2,
        OPM_NORMAL  = 3'd3,
        OPM_FLASH   = 3'd4
    } op_mode_e;

    typedef enum logic [1:0] {
        ADR_CTRL  = 2'b00,
        ADR_SLOT1 = 2'b01,
        ADR_SLOT2 = 2'b10,
        ADR_SLOT3 = 2'b11
    } reg_addr_e;

    typedef struct packed {
        reg_addr_e addr;
        logic      rrs;
        logic      ro;
    } hdr_t;

    function automatic op_mode_e norm_mode(input logic [2:0] raw);
        case (raw)
            3'd1:    return OPM_RESTART;
            3'd2:    return OPM_STANDBY;
            3'd3:    return OPM_NORMAL;
            3'd4:    return OPM_FLASH;
            default: return OPM_STARTUP;
        endcase
    endfunction

    function automatic logic is_run(input op_mode_e m);
        return (m == OPM_STANDBY) || (m == OPM_NORMAL);
    endfunction

    function automatic logic is_boot(input op_mode_e m);
        return (m == OPM_STARTUP) || (m == OPM_RESTART);
    endfunction

endpackage

// File: rtl/sbc_spi_sync.sv
module sbc_spi_sync #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic csn,
    input  logic mosi,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_fall,
    output logic cs_rise,
    output logic mosi_s
);
    localparam int unsigned PW = 3;
    localparam logic [PW-1:0] RST_V = 3'b010;

    logic [PW-1:0] pipe [SYNC_STAGES];
    logic [1:0]    prev_q;
    logic [PW-1:0] last;

    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) pipe[g] <= RST_V;
                    else        pipe[g] <= {sclk, csn, mosi};
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) pipe[g] <= RST_V;
                    else        pipe[g] <= pipe[g-1];
                end
            end
        end
    endgenerate

    assign last = pipe[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 2'b01;
        else        prev_q <= last[2:1];
    end

    assign sclk_rise = last[2] & ~prev_q[1];
    assign sclk_fall = ~last[2] & prev_q[1];
    assign cs_fall   = ~last[1] & prev_q[0];
    assign cs_rise   = last[1] & ~prev_q[0];
    assign mosi_s    = last[0];

endmodule

// File: rtl/sbc_spi_frame.sv
module sbc_spi_frame #(
    parameter int unsigned HDR_BITS  = 4,
    parameter int unsigned DATA_BITS = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sclk_rise,
    input  logic                 sclk_fall,
    input  logic                 cs_fall,
    input  logic                 cs_rise,
    input  logic                 mosi_s,
    input  logic [DATA_BITS-1:0] tx_word,
    output logic                 hdr_load,
    output logic                 commit,
    output logic [HDR_BITS-1:0]  hdr_bits,
    output logic [DATA_BITS-1:0] data_bits,
    output logic                 miso
);
    localparam int unsigned FRAME_BITS = HDR_BITS + DATA_BITS;
    localparam int unsigned CNT_W      = $clog2(FRAME_BITS + 2);
    localparam logic [CNT_W-1:0] HDR_LAST   = CNT_W'(HDR_BITS - 1);
    localparam logic [CNT_W-1:0] FRAME_LAST = CNT_W'(FRAME_BITS - 1);

    typedef enum logic [2:0] {
        S_IDLE, S_HDR, S_LOAD, S_DATA, S_FULL, S_OVER, S_COMMIT
    } fstate_e;

    fstate_e                 state_q, state_d;
    logic [CNT_W-1:0]        cnt_q;
    logic [FRAME_BITS-1:0]   rx_q;
    logic [DATA_BITS-1:0]    tx_q;
    logic                    miso_q;
    logic                    shifting;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (cs_fall) state_d = S_HDR;
            S_HDR: begin
                if (cs_rise)                               state_d = S_IDLE;
                else if (sclk_rise && cnt_q == HDR_LAST)   state_d = S_LOAD;
            end
            S_LOAD:   state_d = cs_rise ? S_IDLE : S_DATA;
            S_DATA: begin
                if (cs_rise)                               state_d = S_IDLE;
                else if (sclk_rise && cnt_q == FRAME_LAST) state_d = S_FULL;
            end
            S_FULL: begin
                if (cs_rise)        state_d = S_COMMIT;
                else if (sclk_rise) state_d = S_OVER;
            end
            S_OVER:   if (cs_rise) state_d = S_IDLE;
            S_COMMIT: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        hdr_load  = (state_q == S_LOAD);
        commit    = (state_q == S_COMMIT);
        hdr_bits  = rx_q[HDR_BITS-1:0];
        data_bits = rx_q[DATA_BITS-1:0];
        miso      = miso_q;
        shifting  = (state_q == S_HDR) || (state_q == S_DATA) || (state_q == S_FULL);
    end

    // shift datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            rx_q   <= '0;
            tx_q   <= '0;
            miso_q <= 1'b0;
        end else if (state_q == S_IDLE) begin
            cnt_q  <= '0;
            rx_q   <= '0;
            tx_q   <= '0;
            miso_q <= 1'b0;
        end else begin
            if (sclk_rise && shifting) begin
                rx_q  <= {rx_q[FRAME_BITS-2:0], mosi_s};
                cnt_q <= cnt_q + 1'b1;
            end
            if (state_q == S_LOAD) begin
                tx_q <= tx_word;
            end else if (sclk_fall) begin
                miso_q <= tx_q[DATA_BITS-1];
                tx_q   <= {tx_q[DATA_BITS-2:0], 1'b0};
            end
        end
    end

endmodule

// File: rtl/sbc_mode_check.sv
module sbc_mode_check
    import sbc_regif_pkg::*;
#(
    parameter int unsigned DATA_W          = 12,
    parameter logic [7:0]  LEGAL_MODE_MASK = 8'b0001_1110,
    parameter logic [15:0] LEGAL_WD_MASK   = 16'h1FFE
) (
    input  logic [DATA_W-1:0] word,
    output logic              legal
);
    logic [MC_W-1:0] mc;
    logic [WD_W-1:0] wd;

    always_comb begin
        mc    = word[MC_LSB +: MC_W];
        wd    = word[WD_LSB +: WD_W];
        legal = LEGAL_MODE_MASK[mc] & LEGAL_WD_MASK[wd];
    end

endmodule

// File: rtl/sbc_reg_bank.sv
module sbc_reg_bank
    import sbc_regif_pkg::*;
#(
    parameter int unsigned DATA_W          = 12,
    parameter logic [7:0]  LEGAL_MODE_MASK = 8'b0001_1110,
    parameter logic [15:0] LEGAL_WD_MASK   = 16'h1FFE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hdr_load,
    input  logic [HDR_W-1:0]  hdr_bits,
    input  logic [2:0]        op_mode_raw,
    input  logic              commit,
    input  logic [DATA_W-1:0] data,
    input  logic [DATA_W-1:0] stat_in,
    input  logic [DATA_W-1:0] diag_in,
    input  logic [DATA_W-1:0] irq_in,
    output logic [DATA_W-1:0] fb_word,
    output logic [DATA_W-1:0] mode_q,
    output logic [DATA_W-1:0] ie_q,
    output logic [DATA_W-1:0] smode_q,
    output logic [DATA_W-1:0] cfg_q,
    output logic [DATA_W-1:0] gp0_q,
    output logic [DATA_W-1:0] gp1_q,
    output logic [DATA_W-1:0] phy_q,
    output logic              wd_kick,
    output logic              rst_req
);
    hdr_t     hdr_now, hdr_q;
    op_mode_e mode_now, mode_lat;
    logic     legal;

    sbc_mode_check #(
        .DATA_W         (DATA_W),
        .LEGAL_MODE_MASK(LEGAL_MODE_MASK),
        .LEGAL_WD_MASK  (LEGAL_WD_MASK)
    ) u_mchk (
        .word (data),
        .legal(legal)
    );

    // feedback selection from the header just received
    always_comb begin
        hdr_now  = hdr_t'(hdr_bits);
        mode_now = norm_mode(op_mode_raw);
        unique case (hdr_now.addr)
            ADR_CTRL:  fb_word = hdr_now.rrs ? diag_in : stat_in;
            ADR_SLOT1: fb_word = !hdr_now.rrs ? ie_q :
                                 (is_run(mode_now) ? irq_in : smode_q);
            ADR_SLOT2: fb_word = hdr_now.rrs ? gp0_q : cfg_q;
            ADR_SLOT3: fb_word = hdr_now.rrs ? gp1_q : phy_q;
            default:   fb_word = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hdr_q    <= '0;
            mode_lat <= OPM_STARTUP;
            mode_q   <= '0;
            ie_q     <= '0;
            smode_q  <= '0;
            cfg_q    <= '0;
            gp0_q    <= '0;
            gp1_q    <= '0;
            phy_q    <= '0;
            wd_kick  <= 1'b0;
            rst_req  <= 1'b0;
        end else begin
            wd_kick <= 1'b0;
            rst_req <= 1'b0;
            if (hdr_load) begin
                hdr_q    <= hdr_now;
                mode_lat <= mode_now;
            end
            if (commit && !hdr_q.ro) begin
                unique case (hdr_q.addr)
                    ADR_CTRL: begin
                        if (legal) begin
                            mode_q  <= data;
                            wd_kick <= 1'b1;
                        end else begin
                            rst_req <= 1'b1;
                        end
                    end
                    ADR_SLOT1: begin
                        if (is_boot(mode_lat)) smode_q <= data;
                        else                   ie_q    <= data;
                    end
                    ADR_SLOT2: begin
                        if (is_run(mode_lat)) cfg_q <= data;
                        else                  gp0_q <= data;
                    end
                    ADR_SLOT3: begin
                        if (is_run(mode_lat)) phy_q <= data;
                        else                  gp1_q <= data;
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/sbc_spi_regif.sv
module sbc_spi_regif
    import sbc_regif_pkg::*;
#(
    parameter int unsigned DATA_W          = 12,
    parameter int unsigned SYNC_STAGES     = 2,
    parameter logic [7:0]  LEGAL_MODE_MASK = 8'b0001_1110,
    parameter logic [15:0] LEGAL_WD_MASK   = 16'h1FFE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sclk,
    input  logic              spi_csn,
    input  logic              spi_mosi,
    output logic              spi_miso,
    input  logic [2:0]        op_mode,
    input  logic [DATA_W-1:0] stat_in,
    input  logic [DATA_W-1:0] diag_in,
    input  logic [DATA_W-1:0] irq_in,
    output logic [DATA_W-1:0] mode_word,
    output logic [DATA_W-1:0] ie_word,
    output logic [DATA_W-1:0] smode_word,
    output logic [DATA_W-1:0] cfg_word,
    output logic [DATA_W-1:0] gp0_word,
    output logic [DATA_W-1:0] gp1_word,
    output logic [DATA_W-1:0] phy_word,
    output logic              glob_en,
    output logic              sdm_en,
    output logic              wd_kick,
    output logic              rst_req
);
    logic              sclk_rise, sclk_fall, cs_fall, cs_rise, mosi_s;
    logic              hdr_load, commit;
    logic [HDR_W-1:0]  hdr_bits;
    logic [DATA_W-1:0] data_bits, fb_word;

    sbc_spi_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk     (spi_sclk),
        .csn      (spi_csn),
        .mosi     (spi_mosi),
        .sclk_rise(sclk_rise),
        .sclk_fall(sclk_fall),
        .cs_fall  (cs_fall),
        .cs_rise  (cs_rise),
        .mosi_s   (mosi_s)
    );

    sbc_spi_frame #(.HDR_BITS(HDR_W), .DATA_BITS(DATA_W)) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_rise(sclk_rise),
        .sclk_fall(sclk_fall),
        .cs_fall  (cs_fall),
        .cs_rise  (cs_rise),
        .mosi_s   (mosi_s),
        .tx_word  (fb_word),
        .hdr_load (hdr_load),
        .commit   (commit),
        .hdr_bits (hdr_bits),
        .data_bits(data_bits),
        .miso     (spi_miso)
    );

    sbc_reg_bank #(
        .DATA_W         (DATA_W),
        .LEGAL_MODE_MASK(LEGAL_MODE_MASK),
        .LEGAL_WD_MASK  (LEGAL_WD_MASK)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .hdr_load   (hdr_load),
        .hdr_bits   (hdr_bits),
        .op_mode_raw(op_mode),
        .commit     (commit),
        .data       (data_bits),
        .stat_in    (stat_in),
        .diag_in    (diag_in),
        .irq_in     (irq_in),
        .fb_word    (fb_word),
        .mode_q     (mode_word),
        .ie_q       (ie_word),
        .smode_q    (smode_word),
        .cfg_q      (cfg_word),
        .gp0_q      (gp0_word),
        .gp1_q      (gp1_word),
        .phy_q      (phy_word),
        .wd_kick    (wd_kick),
        .rst_req    (rst_req)
    );

    assign glob_en = mode_word[EN_BIT];
    assign sdm_en  = mode_word[SDM_BIT];

endmodule

// File: rtl/sbc_spi_regif_chk.sv
module sbc_spi_regif_chk #(
    parameter int unsigned DATA_W          = 12,
    parameter logic [7:0]  LEGAL_MODE_MASK = 8'b0001_1110,
    parameter logic [15:0] LEGAL_WD_MASK   = 16'h1FFE
) (
    input logic              clk,
    input logic              rst_n,
    input logic              spi_csn,
    input logic              wd_kick,
    input logic              rst_req,
    input logic              glob_en,
    input logic [DATA_W-1:0] mode_word,
    input logic [DATA_W-1:0] ie_word,
    input logic [DATA_W-1:0] cfg_word,
    input logic [DATA_W-1:0] phy_word
);
    AST_KICK_RST_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(wd_kick && rst_req)); // R7
    AST_KICK_PULSE: assert property (@(posedge clk) disable iff (!rst_n) wd_kick |=> !wd_kick); // R6
    AST_RST_PULSE: assert property (@(posedge clk) disable iff (!rst_n) rst_req |=> !rst_req); // R7
    AST_KICK_LEGAL: assert property (@(posedge clk) disable iff (!rst_n) wd_kick |-> (LEGAL_MODE_MASK[mode_word[7:5]] && LEGAL_WD_MASK[mode_word[11:8]])); // R6
    AST_MODE_ONLY_KICK: assert property (@(posedge clk) disable iff (!rst_n) (mode_word != $past(mode_word)) |-> wd_kick); // R6
    AST_RST_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rst_n) rst_req |-> (mode_word == $past(mode_word))); // R7
    AST_WRITE_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n) ({ie_word, cfg_word, phy_word} != $past({ie_word, cfg_word, phy_word})) |-> spi_csn); // R10
    AST_EN_ROSE_KICK: assert property (@(posedge clk) disable iff (!rst_n) $rose(glob_en) |-> wd_kick); // R8
endmodule

bind sbc_spi_regif sbc_spi_regif_chk #(
    .DATA_W         (DATA_W),
    .LEGAL_MODE_MASK(LEGAL_MODE_MASK),
    .LEGAL_WD_MASK  (LEGAL_WD_MASK)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .spi_csn  (spi_csn),
    .wd_kick  (wd_kick),
    .rst_req  (rst_req),
    .glob_en  (glob_en),
    .mode_word(mode_word),
    .ie_word  (ie_word),
    .cfg_word (cfg_word),
    .phy_word (phy_word)
);

// File: tb/sbc_spi_regif_tb.sv
module sbc_spi_regif_tb;
    localparam int DW = 12;
    localparam int HALF = 8;

    logic          clk = 1'b0, rst_n = 1'b0;
    logic          sclk = 1'b0, csn = 1'b1, mosi = 1'b0;
    logic [2:0]    op_mode = 3'd0;
    logic [DW-1:0] stat_in = '0, diag_in = '0, irq_in = '0;
    logic          miso, glob_en, sdm_en, wd_kick, rst_req;
    logic [DW-1:0] mode_word, ie_word, smode_word, cfg_word, gp0_word, gp1_word, phy_word;

    always #2 clk = ~clk;

    sbc_spi_regif u_dut (
        .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_csn(csn), .spi_mosi(mosi),
        .spi_miso(miso), .op_mode(op_mode), .stat_in(stat_in), .diag_in(diag_in),
        .irq_in(irq_in), .mode_word(mode_word), .ie_word(ie_word), .smode_word(smode_word),
        .cfg_word(cfg_word), .gp0_word(gp0_word), .gp1_word(gp1_word), .phy_word(phy_word),
        .glob_en(glob_en), .sdm_en(sdm_en), .wd_kick(wd_kick), .rst_req(rst_req)
    );

    int n_chk = 0, n_err = 0, kick_cnt = 0, rst_cnt = 0;
    bit done = 1'b0;
    logic [DW-1:0] m_mode = '0, m_ie = '0, m_sm = '0, m_cfg = '0, m_gp0 = '0, m_gp1 = '0, m_phy = '0;

    always @(posedge clk) begin
        if (wd_kick) kick_cnt++;
        if (rst_req) rst_cnt++;
    end

    function automatic logic [2:0] nm(input logic [2:0] r);
        return (r > 3'd4) ? 3'd0 : r;
    endfunction
    function automatic bit runm(input logic [2:0] m);
        return (m == 3'd2) || (m == 3'd3);
    endfunction
    function automatic bit legal_w(input logic [DW-1:0] w);
        return (w[7:5] >= 3'd1) && (w[7:5] <= 3'd4) && (w[11:8] >= 4'd1) && (w[11:8] <= 4'd12);
    endfunction
    function automatic logic [DW-1:0] exp_fb(input logic [1:0] a, input logic s, input logic [2:0] m);
        case (a)
            2'b00:   return s ? diag_in : stat_in;
            2'b01:   return !s ? m_ie : (runm(m) ? irq_in : m_sm);
            2'b10:   return s ? m_gp0 : m_cfg;
            default: return s ? m_gp1 : m_phy;
        endcase
    endfunction

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_regs(input string tag);
        chk({"R6 mode_word ", tag}, 32'(mode_word), 32'(m_mode));
        chk({"R4 ie_word ", tag}, 32'(ie_word), 32'(m_ie));
        chk({"R4 smode_word ", tag}, 32'(smode_word), 32'(m_sm));
        chk({"R4 cfg_word ", tag}, 32'(cfg_word), 32'(m_cfg));
        chk({"R4 gp0_word ", tag}, 32'(gp0_word), 32'(m_gp0));
        chk({"R4 gp1_word ", tag}, 32'(gp1_word), 32'(m_gp1));
        chk({"R4 phy_word ", tag}, 32'(phy_word), 32'(m_phy));
        chk({"R8 glob_en ", tag}, 32'(glob_en), 32'(m_mode[4]));
        chk({"R8 sdm_en ", tag}, 32'(sdm_en), 32'(m_mode[3]));
    endtask

    task automatic do_frame(input logic [15:0] fr, input int nbits, input string tag);
        logic [2:0]  m;
        logic [15:0] rx, exp_rx;
        logic [16:0] v;
        logic [83:0] snap;
        int k0, r0, ek, er;
        m = nm(op_mode);
        exp_rx = {4'b0000, exp_fb(fr[15:14], fr[13], m)};
        k0 = kick_cnt; r0 = rst_cnt; ek = 0; er = 0;
        snap = {mode_word, ie_word, smode_word, cfg_word, gp0_word, gp1_word, phy_word};
        v = (nbits == 17) ? {fr, 1'b0} : (nbits == 15) ? {2'b00, fr[15:1]} : {1'b0, fr};
        rx = '0;
        @(negedge clk) csn = 1'b0;
        wait_clks(HALF);
        for (int i = nbits - 1; i >= 0; i--) begin
            mosi = v[i];
            wait_clks(HALF);
            rx = {rx[14:0], miso};
            sclk = 1'b1;
            wait_clks(HALF);
            sclk = 1'b0;
        end
        wait_clks(HALF);
        chk({"R10 held-while-selected ", tag},
            32'({mode_word, ie_word, smode_word, cfg_word, gp0_word, gp1_word, phy_word} != snap), 32'd0);
        csn = 1'b1;
        wait_clks(12);
        if (nbits == 16) begin
            chk({"R3 read-data ", tag}, 32'(rx), 32'(exp_rx));
            if (!fr[12]) begin
                case (fr[15:14])
                    2'b00: if (legal_w(fr[11:0])) begin m_mode = fr[11:0]; ek = 1; end else er = 1;
                    2'b01: if (m <= 3'd1) m_sm = fr[11:0]; else m_ie = fr[11:0];
                    2'b10: if (runm(m)) m_cfg = fr[11:0]; else m_gp0 = fr[11:0];
                    default: if (runm(m)) m_phy = fr[11:0]; else m_gp1 = fr[11:0];
                endcase
            end
        end
        chk_regs(tag);
        chk({"R6 kick-count ", tag}, 32'(kick_cnt - k0), 32'(ek));
        chk({"R7 rst-count ", tag}, 32'(rst_cnt - r0), 32'(er));
    endtask

    initial begin
        wait_clks(150000);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        wait_clks(5);
        rst_n = 1'b1;
        wait_clks(3);
        // R1 reset state
        chk_regs("R1 reset");
        chk("R1 miso", 32'(miso), 32'd0);
        chk("R1 strobes", 32'({wd_kick, rst_req}), 32'd0);

        // directed cases
        op_mode = 3'd0;
        do_frame({4'b0000, 4'd5, 3'd2, 1'b1, 1'b0, 3'd0}, 16, "R6 legal-ctrl");
        do_frame({4'b0000, 4'd0, 3'd2, 1'b0, 1'b0, 3'd0}, 16, "R7 bad-wd");
        do_frame({4'b0000, 4'd3, 3'd7, 1'b0, 1'b1, 3'd0}, 16, "R7 bad-mode");
        do_frame({4'b0000, 4'd13, 3'd1, 1'b0, 1'b1, 3'd0}, 16, "R7 wd13");
        do_frame({4'b0001, 12'hA5A}, 16, "R5 ro-ctrl");
        do_frame({4'b0100, 12'h3C3}, 16, "R4 boot-slot1");
        do_frame({4'b0101, 12'hFFF}, 16, "R5 ro-slot1");
        do_frame({4'b0110, 12'h000}, 16, "R3 readback-slot1");
        do_frame({4'b1000, 12'h777}, 15, "R2 short");
        do_frame({4'b1000, 12'h777}, 17, "R2 long");
        op_mode = 3'd6;
        do_frame({4'b1100, 12'h123}, 16, "R9 undef-mode");
        op_mode = 3'd4;
        do_frame({4'b0100, 12'h456}, 16, "R4 flash-slot1");
        op_mode = 3'd3;
        irq_in = 12'h9B1;
        do_frame({4'b0110, 12'h000}, 16, "R3 run-irq");

        // constrained random
        for (int n = 0; n < 200; n++) begin
            op_mode = 3'($urandom_range(0, 7));
            stat_in = 12'($urandom);
            diag_in = 12'($urandom);
            irq_in  = 12'($urandom);
            do_frame(16'($urandom), 16, $sformatf("rand%0d", n));
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule